// File: doc/BRIEF.md
# Register-Operand Negate, Multiply and Shift Unit

This unit executes two one-operand instruction groups on a 32-bit general register. A request carries a group select and the ModR/M byte: the low three bits pick the register operand, the middle three bits pick the operation, and the top two bits must encode register-direct addressing. The first group inverts, negates, or multiplies the accumulator by the operand without sign. The second group shifts the operand left, right with zero fill, or right with sign fill. The shift count comes from the low byte of the count register.

The unit has no storage for operands. It reads a register file through two combinational read ports and writes results through one write port. It holds the sign, zero and overflow flags. The multiply is iterative and takes several cycles. While an operation is in progress `ready` is low, and `done` pulses once every write for the operation has finished.

Top module: `ums_unit`

## Requirements
- R1: The operation is taken from modrm[5:3] and the register from modrm[2:0]. With shift_grp=0 the legal codes are 2 (invert), 3 (negate) and 4 (unsigned multiply). With shift_grp=1 they are 4 (shift left), 5 (logical right) and 7 (arithmetic right). modrm[7:6] must be 2'b11. Any other request raises `illegal` for one cycle, one cycle after `start`. It writes no register, leaves the flags as they were and gives no `done`.
- R2: Invert stores the bitwise complement of the operand. SF takes result bit 31, ZF is set when the result is zero, and OF is cleared.
- R3: Negate stores 0 minus the operand. SF and ZF follow the result, and OF is cleared.
- R4: Negate of 0x80000000 leaves the register unchanged and sets SF=1, ZF=0, OF=1.
- R5: Multiply forms the unsigned product of register 0 and the operand. The low half goes to register 0 and the high half to register 2. OF is set exactly when the high half is nonzero, and SF and ZF are left alone.
- R6: The shift count is bits [4:0] of register 1. A count of 0 writes the operand back unchanged, completes with `done`, and leaves all flags unchanged.
- R7: Shift left fills with zeros. SF and ZF follow the result, and with a count of 1, OF becomes bit 31 XOR bit 30 of the original operand.
- R8: Logical right shift fills with zeros and clears SF. ZF follows the result, and with a count of 1, OF becomes bit 31 of the original operand.
- R9: Arithmetic right shift fills with the sign bit. SF and ZF follow the result, and with a count of 1, OF is cleared.
- R10: For any shift whose masked count is not 1, OF keeps its previous value.
- R11: `ready` is high only when the unit is idle, and `start` is ignored while `ready` is low. `done` is a one-cycle pulse, seen only once all writes for the operation are in the register file. Register writes and flag changes occur only while the unit is busy.
- R12: After reset `ready`=1, `done`=0, `illegal`=0, `rf_we`=0 and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken when ready is high |
| shift_grp | input | 1 | 0: invert/negate/multiply group, 1: shift group |
| modrm | input | 8 | Addressing byte: mode [7:6], operation [5:3], register [2:0] |
| ready | output | 1 | Unit idle and able to take a request |
| done | output | 1 | One-cycle pulse when an operation completes |
| illegal | output | 1 | One-cycle pulse for a rejected request |
| rf_ra_a | output | 3 | Read address for the operand register |
| rf_rd_a | input | 32 | Operand register data (combinational read) |
| rf_ra_b | output | 3 | Read address for the accumulator or count register |
| rf_rd_b | input | 32 | Accumulator or count register data |
| rf_we | output | 1 | Register file write enable |
| rf_wa | output | 3 | Register file write address |
| rf_wd | output | 32 | Register file write data |
| flag_sf | output | 1 | Sign flag |
| flag_zf | output | 1 | Zero flag |
| flag_of | output | 1 | Overflow flag |

## Verification
A controller state that lingers or skips ahead shows at the ports as a `done` that never comes, comes twice, or comes before both multiply halves are written. The bench catches this within the same operation by reading the registers the moment `done` rises. A wrong flag register shows on the flag outputs in the cycle `done` rises. The cases that keep state are the most revealing: a shift count of 0 or above 1, and the special negate. In these an unchanged flag or register is the expected answer, so a stray update is caught at once. A stale operation code left from an earlier request shows up as a write during a rejected or ignored `start`.

// File: rtl/ums_pkg.sv
package ums_pkg;

    localparam int unsigned RIDX_W = 3;

    // Fixed register roles used by the multiply and shift groups
    localparam logic [RIDX_W-1:0] IDX_ACC = 3'd0;
    localparam logic [RIDX_W-1:0] IDX_CNT = 3'd1;
    localparam logic [RIDX_W-1:0] IDX_HI  = 3'd2;

    typedef enum logic [2:0] {
        OP_NOT,
        OP_NEG,
        OP_MUL,
        OP_SHL,
        OP_SHR,
        OP_SAR
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_MULW,
        ST_WLO,
        ST_WHI
    } st_e;

    typedef struct packed {
        logic sf;
        logic zf;
        logic of;
    } flags_t;

endpackage

// File: rtl/ums_decode.sv
module ums_decode
    import ums_pkg::*;
(
    input  logic              shift_grp,
    input  logic [7:0]        modrm,
    output op_e               op,
    output logic              legal,
    output logic [RIDX_W-1:0] rm
);

    logic [2:0] sub;

    always_comb begin
        sub   = modrm[5:3];
        rm    = modrm[2:0];
        op    = OP_NOT;
        legal = 1'b0;
        if (modrm[7:6] == 2'b11) begin
            if (!shift_grp) begin
                unique case (sub)
                    3'd2:    begin op = OP_NOT; legal = 1'b1; end
                    3'd3:    begin op = OP_NEG; legal = 1'b1; end
                    3'd4:    begin op = OP_MUL; legal = 1'b1; end
                    default: legal = 1'b0;
                endcase
            end else begin
                unique case (sub)
                    3'd4:    begin op = OP_SHL; legal = 1'b1; end
                    3'd5:    begin op = OP_SHR; legal = 1'b1; end
                    3'd7:    begin op = OP_SAR; legal = 1'b1; end
                    default: legal = 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/ums_alu.sv
module ums_alu
    import ums_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = $clog2(DATA_W)
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] opa,
    input  logic [CNT_W-1:0]  cnt,
    input  flags_t            flg_i,
    output logic [DATA_W-1:0] res,
    output logic              we,
    output flags_t            flg_o
);

    localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);

    logic cnt_zero;
    logic cnt_one;

    always_comb begin
        cnt_zero = (cnt == '0);
        cnt_one  = (cnt == CNT_ONE);
        res      = opa;
        we       = 1'b1;
        flg_o    = flg_i;
        unique case (op)
            OP_NOT: begin
                res      = ~opa;
                flg_o.sf = res[DATA_W-1];
                flg_o.zf = (res == '0);
                flg_o.of = 1'b0;
            end
            OP_NEG: begin
                if (opa == MIN_NEG) begin
                    we       = 1'b0;
                    flg_o.sf = 1'b1;
                    flg_o.zf = 1'b0;
                    flg_o.of = 1'b1;
                end else begin
                    res      = '0 - opa;
                    flg_o.sf = res[DATA_W-1];
                    flg_o.zf = (res == '0);
                    flg_o.of = 1'b0;
                end
            end
            OP_SHL: begin
                if (!cnt_zero) begin
                    res      = opa << cnt;
                    flg_o.sf = res[DATA_W-1];
                    flg_o.zf = (res == '0);
                    if (cnt_one) flg_o.of = opa[DATA_W-1] ^ opa[DATA_W-2];
                end
            end
            OP_SHR: begin
                if (!cnt_zero) begin
                    res      = opa >> cnt;
                    flg_o.sf = 1'b0;
                    flg_o.zf = (res == '0);
                    if (cnt_one) flg_o.of = opa[DATA_W-1];
                end
            end
            OP_SAR: begin
                if (!cnt_zero) begin
                    res      = $signed(opa) >>> cnt;
                    flg_o.sf = res[DATA_W-1];
                    flg_o.zf = (res == '0);
                    if (cnt_one) flg_o.of = 1'b0;
                end
            end
            default: begin
                we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ums_mul.sv
module ums_mul #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned STEP   = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic [DATA_W-1:0]   mcand,
    input  logic [DATA_W-1:0]   mplier,
    output logic                fin,
    output logic [2*DATA_W-1:0] prod
);

    // STEP must divide DATA_W and be smaller than it
    localparam int unsigned ITER   = DATA_W / STEP;
    localparam int unsigned CNTW   = $clog2(ITER + 1);
    localparam logic [CNTW-1:0] LAST = CNTW'(ITER - 1);

    logic [2*DATA_W-1:0]    acc_d, acc_q;
    logic [DATA_W-1:0]      mc_d, mc_q;
    logic [CNTW-1:0]        cnt_d, cnt_q;
    logic                   run_d, run_q;
    logic                   fin_d, fin_q;
    logic [DATA_W+STEP-1:0] part;
    logic [DATA_W+STEP-1:0] upper;

    always_comb begin
        part  = {{STEP{1'b0}}, mc_q} * {{DATA_W{1'b0}}, acc_q[STEP-1:0]};
        upper = {{STEP{1'b0}}, acc_q[2*DATA_W-1:DATA_W]} + part;
        acc_d = acc_q;
        mc_d  = mc_q;
        cnt_d = cnt_q;
        run_d = run_q;
        fin_d = 1'b0;
        if (go) begin
            acc_d = {{DATA_W{1'b0}}, mplier};
            mc_d  = mcand;
            cnt_d = '0;
            run_d = 1'b1;
        end else if (run_q) begin
            acc_d = {upper, acc_q[DATA_W-1:STEP]};
            cnt_d = cnt_q + CNTW'(1);
            if (cnt_q == LAST) begin
                run_d = 1'b0;
                fin_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            mc_q  <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            fin_q <= 1'b0;
        end else begin
            acc_q <= acc_d;
            mc_q  <= mc_d;
            cnt_q <= cnt_d;
            run_q <= run_d;
            fin_q <= fin_d;
        end
    end

    assign fin  = fin_q;
    assign prod = acc_q;

endmodule

// File: rtl/ums_unit.sv
module ums_unit
    import ums_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned MUL_STEP = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              shift_grp,
    input  logic [7:0]        modrm,
    output logic              ready,
    output logic              done,
    output logic              illegal,
    output logic [RIDX_W-1:0] rf_ra_a,
    input  logic [DATA_W-1:0] rf_rd_a,
    output logic [RIDX_W-1:0] rf_ra_b,
    input  logic [DATA_W-1:0] rf_rd_b,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_wa,
    output logic [DATA_W-1:0] rf_wd,
    output logic              flag_sf,
    output logic              flag_zf,
    output logic              flag_of
);

    localparam int unsigned CNT_W = $clog2(DATA_W);

    typedef struct packed {
        st_e               st;
        op_e               op;
        logic [RIDX_W-1:0] rm;
        logic              done;
        logic              ill;
        flags_t            flg;
    } ctl_t;

    ctl_t d, q;

    op_e               dec_op;
    logic              dec_legal;
    logic [RIDX_W-1:0] dec_rm;
    logic [DATA_W-1:0] alu_res;
    logic              alu_we;
    flags_t            alu_flg;
    logic              mul_go;
    logic              mul_fin;
    logic [2*DATA_W-1:0] mul_prod;

    ums_decode u_dec (
        .shift_grp (shift_grp),
        .modrm     (modrm),
        .op        (dec_op),
        .legal     (dec_legal),
        .rm        (dec_rm)
    );

    ums_alu #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_alu (
        .op    (q.op),
        .opa   (rf_rd_a),
        .cnt   (rf_rd_b[CNT_W-1:0]),
        .flg_i (q.flg),
        .res   (alu_res),
        .we    (alu_we),
        .flg_o (alu_flg)
    );

    ums_mul #(.DATA_W(DATA_W), .STEP(MUL_STEP)) u_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (mul_go),
        .mcand  (rf_rd_b),
        .mplier (rf_rd_a),
        .fin    (mul_fin),
        .prod   (mul_prod)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.ill   = 1'b0;
        rf_ra_a = q.rm;
        rf_ra_b = (q.op == OP_MUL) ? IDX_ACC : IDX_CNT;
        rf_we   = 1'b0;
        rf_wa   = q.rm;
        rf_wd   = alu_res;
        mul_go  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    if (dec_legal) begin
                        d.op = dec_op;
                        d.rm = dec_rm;
                        d.st = ST_READ;
                    end else begin
                        d.ill = 1'b1;
                    end
                end
            end
            ST_READ: begin
                if (q.op == OP_MUL) begin
                    mul_go = 1'b1;
                    d.st   = ST_MULW;
                end else begin
                    rf_we  = alu_we;
                    d.flg  = alu_flg;
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            ST_MULW: begin
                if (mul_fin) d.st = ST_WLO;
            end
            ST_WLO: begin
                rf_we = 1'b1;
                rf_wa = IDX_ACC;
                rf_wd = mul_prod[DATA_W-1:0];
                d.st  = ST_WHI;
            end
            ST_WHI: begin
                rf_we    = 1'b1;
                rf_wa    = IDX_HI;
                rf_wd    = mul_prod[2*DATA_W-1:DATA_W];
                d.flg.of = |mul_prod[2*DATA_W-1:DATA_W];
                d.done   = 1'b1;
                d.st     = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.op   <= OP_NOT;
            q.rm   <= '0;
            q.done <= 1'b0;
            q.ill  <= 1'b0;
            q.flg  <= '0;
        end else begin
            q <= d;
        end
    end

    assign ready   = (q.st == ST_IDLE);
    assign done    = q.done;
    assign illegal = q.ill;
    assign flag_sf = q.flg.sf;
    assign flag_zf = q.flg.zf;
    assign flag_of = q.flg.of;

endmodule

// File: rtl/ums_checker.sv
module ums_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       ready,
    input logic       done,
    input logic       illegal,
    input logic       rf_we,
    input logic [2:0] flags
);

    // R11: completion is reported only when the unit is back to idle
    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);

    // R11: no register write while idle
    p_no_write_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !rf_we);

    // R11: done is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: flags move only in the cycle done is reported
    p_flags_at_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(flags));

    // R1: a rejection follows a start seen while idle
    p_illegal_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> ($past(start) && ready));

    // R1: a rejected request never also completes
    p_ill_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && illegal));

endmodule

bind ums_unit ums_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .ready   (ready),
    .done    (done),
    .illegal (illegal),
    .rf_we   (rf_we),
    .flags   ({flag_sf, flag_zf, flag_of})
);

// File: tb/tb_ums_unit.sv
module tb_ums_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        shift_grp = 1'b0;
    logic [7:0]  modrm = 8'h00;
    logic        ready, done, illegal, rf_we;
    logic [2:0]  rf_ra_a, rf_ra_b, rf_wa;
    logic [31:0] rf_rd_a, rf_rd_b, rf_wd;
    logic        flag_sf, flag_zf, flag_of;

    logic [31:0] regs [8];
    logic        pl_en = 1'b0;
    logic [2:0]  pl_i = 3'd0;
    logic [31:0] pl_v = 32'd0;

    int n_tests = 0;
    int n_fail  = 0;
    int n_done  = 0;

    always #4 clk = ~clk;

    ums_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .shift_grp(shift_grp),
        .modrm(modrm), .ready(ready), .done(done), .illegal(illegal),
        .rf_ra_a(rf_ra_a), .rf_rd_a(rf_rd_a), .rf_ra_b(rf_ra_b),
        .rf_rd_b(rf_rd_b), .rf_we(rf_we), .rf_wa(rf_wa), .rf_wd(rf_wd),
        .flag_sf(flag_sf), .flag_zf(flag_zf), .flag_of(flag_of)
    );

    assign rf_rd_a = regs[rf_ra_a];
    assign rf_rd_b = regs[rf_ra_b];

    always @(posedge clk) begin
        if (pl_en) regs[pl_i] <= pl_v;
        else if (rf_we) regs[rf_wa] <= rf_wd;
        if (done) n_done <= n_done + 1;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_flags(input string req, input logic s, input logic z, input logic o);
        chk(req, "flags sf/zf/of", {29'd0, flag_sf, flag_zf, flag_of}, {29'd0, s, z, o});
    endtask

    task automatic set_reg(input logic [2:0] i, input logic [31:0] v);
        @(negedge clk);
        pl_en = 1'b1; pl_i = i; pl_v = v;
        @(negedge clk);
        pl_en = 1'b0;
    endtask

    task automatic run_op(input logic grp, input logic [7:0] m);
        @(negedge clk);
        shift_grp = grp; modrm = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 300 && !(done || illegal); i++) @(negedge clk);
        if (!(done || illegal)) begin
            n_tests++; n_fail++;
            $display("FAIL R11 completion: actual 0 expected 1");
        end
    endtask

    // modrm codes, register 3 unless noted
    localparam logic [7:0] M_NOT = 8'hD3, M_NEG = 8'hDB, M_MUL_R1 = 8'hE1;
    localparam logic [7:0] M_SHL = 8'hE3, M_SHR = 8'hEB, M_SAR = 8'hFB;

    task automatic t_reset();
        chk("R12", "ready", {31'd0, ready}, 32'd1);
        chk("R12", "done", {31'd0, done}, 32'd0);
        chk("R12", "illegal", {31'd0, illegal}, 32'd0);
        chk("R12", "rf_we", {31'd0, rf_we}, 32'd0);
        chk_flags("R12", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_not();
        set_reg(3, 32'h0F0F00FF);
        run_op(0, M_NOT);
        chk("R2", "not value", regs[3], 32'hF0F0FF00);
        chk_flags("R2", 1'b1, 1'b0, 1'b0);
        set_reg(3, 32'hFFFFFFFF);
        run_op(0, M_NOT);
        chk("R2", "not to zero", regs[3], 32'h0);
        chk_flags("R2", 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_neg();
        set_reg(3, 32'd1);
        run_op(0, M_NEG);
        chk("R3", "neg 1", regs[3], 32'hFFFFFFFF);
        chk_flags("R3", 1'b1, 1'b0, 1'b0);
        set_reg(3, 32'd0);
        run_op(0, M_NEG);
        chk("R3", "neg 0", regs[3], 32'h0);
        chk_flags("R3", 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_neg_min();
        set_reg(3, 32'hFFFFFFFF);
        run_op(0, M_NEG);
        chk("R3", "neg -1", regs[3], 32'd1);
        chk_flags("R3", 1'b0, 1'b0, 1'b0);
        set_reg(3, 32'h80000000);
        run_op(0, M_NEG);
        chk("R4", "min kept", regs[3], 32'h80000000);
        chk_flags("R4", 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_mul();
        logic s0, z0;
        logic [63:0] p;
        set_reg(0, 32'd4); set_reg(1, 32'd3); set_reg(2, 32'hDEAD);
        s0 = flag_sf; z0 = flag_zf;
        run_op(0, M_MUL_R1);
        chk("R5", "lo 4*3", regs[0], 32'd12);
        chk("R5", "hi 4*3", regs[2], 32'd0);
        chk_flags("R5", s0, z0, 1'b0);
        set_reg(0, 32'hFFFFFFFF); set_reg(1, 32'hFFFFFFFF);
        p = {32'd0, 32'hFFFFFFFF} * {32'd0, 32'hFFFFFFFF};
        run_op(0, M_MUL_R1);
        chk("R5", "lo max", regs[0], p[31:0]);
        chk("R5", "hi max", regs[2], p[63:32]);
        chk_flags("R5", s0, z0, 1'b1);
        set_reg(0, 32'h00010000);
        run_op(0, 8'hE0);
        chk("R5", "lo square", regs[0], 32'd0);
        chk("R5", "hi square", regs[2], 32'd1);
        set_reg(0, 32'd5); set_reg(2, 32'd7);
        run_op(0, 8'hE2);
        chk("R5", "lo rm=hi reg", regs[0], 32'd35);
        chk("R5", "hi rm=hi reg", regs[2], 32'd0);
        chk_flags("R5", s0, z0, 1'b0);
    endtask

    task automatic t_shl();
        set_reg(1, 32'd1);
        set_reg(3, 32'd13);
        run_op(1, M_SHL);
        chk("R7", "shl 13", regs[3], 32'd26);
        chk_flags("R7", 1'b0, 1'b0, 1'b0);
        set_reg(3, 32'h40000000);
        run_op(1, M_SHL);
        chk("R7", "shl into sign", regs[3], 32'h80000000);
        chk_flags("R7", 1'b1, 1'b0, 1'b1);
        set_reg(3, 32'h80000000);
        run_op(1, M_SHL);
        chk("R7", "shl out", regs[3], 32'h0);
        chk_flags("R7", 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_shr_sar();
        set_reg(1, 32'd1);
        set_reg(3, 32'hFFFFFFFD);
        run_op(1, M_SHR);
        chk("R8", "shr neg", regs[3], 32'h7FFFFFFE);
        chk_flags("R8", 1'b0, 1'b0, 1'b1);
        set_reg(3, 32'hFFFFFFFD);
        run_op(1, M_SAR);
        chk("R9", "sar neg", regs[3], 32'hFFFFFFFE);
        chk_flags("R9", 1'b1, 1'b0, 1'b0);
        set_reg(1, 32'd31);
        set_reg(3, 32'h80000000);
        run_op(1, M_SAR);
        chk("R9", "sar 31", regs[3], 32'hFFFFFFFF);
        chk_flags("R9", 1'b1, 1'b0, 1'b0);
        set_reg(3, 32'h80000000);
        run_op(1, M_SHR);
        chk("R8", "shr 31", regs[3], 32'd1);
        chk_flags("R8", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_count_mask();
        logic s0, z0, o0;
        int d0;
        set_reg(1, 32'h21);
        set_reg(3, 32'd3);
        run_op(1, M_SHL);
        chk("R6", "count 0x21", regs[3], 32'd6);
        set_reg(1, 32'hFFFFFF04);
        set_reg(3, 32'd1);
        run_op(1, M_SHL);
        chk("R6", "count high bits", regs[3], 32'h10);
        set_reg(1, 32'h20);
        set_reg(3, 32'h80001234);
        s0 = flag_sf; z0 = flag_zf; o0 = flag_of;
        d0 = n_done;
        run_op(1, M_SAR);
        repeat (2) @(negedge clk);
        chk("R6", "count 0 value", regs[3], 32'h80001234);
        chk_flags("R6", s0, z0, o0);
        chk("R6", "count 0 done", n_done - d0, 32'd1);
    endtask

    task automatic t_of_keep();
        set_reg(1, 32'd1);
        set_reg(3, 32'h40000000);
        run_op(1, M_SHL);
        chk_flags("R10", 1'b1, 1'b0, 1'b1);
        set_reg(1, 32'd4);
        set_reg(3, 32'd3);
        run_op(1, M_SHL);
        chk("R10", "shl 4", regs[3], 32'h30);
        chk_flags("R10", 1'b0, 1'b0, 1'b1);
        set_reg(1, 32'd2);
        set_reg(3, 32'h80000000);
        run_op(1, M_SHR);
        chk("R10", "shr 2", regs[3], 32'h20000000);
        chk_flags("R10", 1'b0, 1'b0, 1'b1);
        set_reg(1, 32'd1);
        run_op(1, M_SAR);
        chk_flags("R9", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_illegal();
        logic [7:0] codes [5] = '{8'hC3, 8'hEB, 8'hF3, 8'hC3, 8'h13};
        logic       grps  [5] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
        set_reg(3, 32'h0000A5A5);
        for (int k = 0; k < 5; k++) begin
            logic s0, z0, o0;
            int d0;
            s0 = flag_sf; z0 = flag_zf; o0 = flag_of;
            d0 = n_done;
            run_op(grps[k], codes[k]);
            chk("R1", "illegal pulse", {31'd0, illegal}, 32'd1);
            repeat (2) @(negedge clk);
            chk("R1", "illegal reg kept", regs[3], 32'h0000A5A5);
            chk("R1", "illegal no done", n_done - d0, 32'd0);
            chk_flags("R1", s0, z0, o0);
        end
    endtask

    task automatic t_busy_start();
        int d0;
        set_reg(0, 32'd2); set_reg(1, 32'd3); set_reg(3, 32'h55);
        d0 = n_done;
        @(negedge clk);
        shift_grp = 1'b0; modrm = M_MUL_R1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R11", "busy ready", {31'd0, ready}, 32'd0);
        modrm = M_NOT; start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 300 && !done; i++) @(negedge clk);
        repeat (6) @(negedge clk);
        chk("R11", "mul result", regs[0], 32'd6);
        chk("R11", "ignored start", regs[3], 32'h55);
        chk("R11", "single done", n_done - d0, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R11 watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) regs[i] = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_not();
        t_neg();
        t_neg_min();
        t_mul();
        t_shl();
        t_shr_sar();
        t_count_mask();
        t_of_keep();
        t_illegal();
        t_busy_start();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule